// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product over many clock cycles. It needs only one 32-bit adder and one 64-bit product register. A single-cycle start pulse captures both operands. The multiplier operand is placed in the low half of the product register and the upper half is cleared. The block then runs one iteration per clock.

In each iteration the block looks at bit 0 of the product register. When that bit is set, the multiplicand is added into the upper half. The whole register, including the adder's carry-out, then moves right by one place. After thirty-two iterations the done flag rises. The product is held until the next accepted start.

Signed operands are not handled. A caller with signed values converts them to magnitudes before the call and corrects the sign afterwards.

Top module: `seq_mul`

## Requirements
- R1: Reset is synchronous and active low. A clock edge with `rst_n` low puts the block in its idle state with `done` low and `product` zero, and this also applies part-way through an operation.
- R2: A start accepted while idle or done loads the registers. At the next clock edge `product` equals the multiplier in bits 31:0 with zeros in bits 63:32, and `done` is low.
- R3: When `done` is high, `product` equals the full unsigned 64-bit product of the multiplicand and multiplier captured at the accepted start.
- R4: The carry-out of the 32-bit add enters bit 63 during the shift, so operands with all bits set still give the exact result 0xFFFFFFFE00000001.
- R5: `done` rises at the 33rd rising edge counting the edge that accepted start: one load edge followed by 32 iteration edges.
- R6: While `done` is high and `start` is low, `done` stays high and `product` stays unchanged, even when the operand inputs change.
- R7: A `start` pulse during the 32 iterations is ignored. The running result and its completion time do not change.
- R8: A `start` while `done` is high begins a new operation. `done` is low after the next edge.
- R9: A zero operand on either side gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse, sampled at the clock edge |
| multiplicand | input | 32 | Unsigned multiplicand, captured on start |
| multiplier | input | 32 | Unsigned multiplier, captured on start |
| done | output | 1 | High from completion until the next accepted start |
| product | output | 64 | Product register (final result when done is high) |

## Verification
Two functions can fall in the same cycle: taking a start pulse and stepping an iteration that is already running. The bench provokes this by raising `start` with different operands several cycles into an operation. It then checks that the original product still appears on the 33rd edge. A second case puts the start on the same cycle as a held done state. There the bench expects `done` to fall and the new multiplier to appear in the low half of `product` after one edge.

// File: rtl/seq_mul_pkg.sv
// Package: shared types for the sequential multiplier.
// Assumes: none beyond IEEE 1800-2017 enums.
package seq_mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;
endpackage

// File: rtl/seq_mul_adder.sv
// Module: seq_mul_adder
// Ripple-carry adder built from repeated one-bit full adders.
// Assumes: purely combinational; the caller registers the result.
module seq_mul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end

    assign cout = carry[W];
endmodule

// File: rtl/seq_mul_ctrl.sv
// Module: seq_mul_ctrl
// Sequences one load cycle and W iteration cycles, then holds the done state.
// Assumes: start is synchronous to clk; a start during iterations is dropped.
module seq_mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e    state;
    logic [CW-1:0] iter;

    // Decode strobes from the current state.
    always_comb begin
        step = (state == ST_RUN);
        done = (state == ST_FIN);
        load = start && (state != ST_RUN);
    end

    // State and iteration counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            iter  <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    iter <= iter + 1'b1;
                    if (iter == LAST) state <= ST_FIN;
                end
                default: begin
                    if (start) begin
                        state <= ST_RUN;
                        iter  <= '0;
                    end
                end
            endcase
        end
    end

    // R1: a reset edge always lands in idle.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> state == ST_IDLE);

    // R5: completion only after the last iteration count.
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(iter) == LAST);

    // R7: an unfinished run keeps running whatever start does.
    a_r7_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (step && iter != LAST) |=> step);
endmodule

// File: rtl/seq_mul_datapath.sv
// Module: seq_mul_datapath
// Holds the multiplicand and the 2W-bit product register.
// Performs the conditional add into the upper half, then the right shift with carry.
// Assumes: load and step are never high together (the controller guarantees this).
module seq_mul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W-1:0] mcand;
    logic [W-1:0] add_sum;
    logic         add_cout;

    seq_mul_adder #(.W(W)) u_adder (
        .a    (prod[PW-1:W]),
        .b    (mcand),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Load operands, or run one test-add-shift iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod  <= '0;
            mcand <= '0;
        end else if (load) begin
            prod  <= {{W{1'b0}}, mplier_in};
            mcand <= mcand_in;
        end else if (step) begin
            if (prod[0]) prod <= {add_cout, add_sum, prod[W-1:1]};
            else         prod <= {1'b0, prod[PW-1:1]};
        end
    end

    // R2: a load leaves the multiplier in the low half and clears the upper half.
    a_r2_load_layout: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod[PW-1:W] == '0) && (prod[W-1:0] == $past(mplier_in)));

    // R4: a carry out of the add must end up in the top bit.
    a_r4_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step && prod[0] && add_cout) |=> prod[PW-1]);
endmodule

// File: rtl/seq_mul.sv
// Module: seq_mul (top)
// Unsigned W x W sequential multiplier with a 2W-bit product.
// Assumes: unsigned operands; start is a pulse sampled at the clock edge.
module seq_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic load;
    logic step;

    seq_mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    seq_mul_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .prod      (product)
    );

    // R6: with no start, a finished result stays put.
    a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    // R8: a start on a finished result begins a new run.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
endmodule

// File: tb/seq_mul_tb.sv
module seq_mul_tb;
    localparam int W  = 32;
    localparam int NV = 8;

    localparam logic [W-1:0] VA [NV] = '{
        32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678,
        32'h8000_0000, 32'hDEAD_BEEF, 32'h0000_0001, 32'h7FFF_FFFF };
    localparam logic [W-1:0] VB [NV] = '{
        32'h0000_0005, 32'hFFFF_FFFF, 32'hCAFE_BABE, 32'h9ABC_DEF0,
        32'h0000_0002, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001 };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   multiplicand = '0;
    logic [W-1:0]   multiplier = '0;
    logic           done;
    logic [2*W-1:0] product;

    int n_vec = 0;
    int n_bad = 0;

    seq_mul #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .multiplicand(multiplicand), .multiplier(multiplier),
        .done(done), .product(product)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pulse start for one edge, check the load image, wait for done.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int glitch_at, input string req);
        int cyc;
        @(negedge clk);
        multiplicand = a; multiplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, "/R2 load image"}, product, {32'h0, b});
        check({req, "/R8 done low after start"}, {63'h0, done}, 64'h0);
        cyc = 1;
        while (!done && cyc < 100) begin
            if (cyc == glitch_at) begin
                multiplicand = ~a; multiplier = b + 32'd7; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check({req, "/R5 latency"}, 64'(cyc), 64'd33);
        check({req, "/R3 product"}, product, 64'(a) * 64'(b));
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] held;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 done after reset", {63'h0, done}, 64'h0);
        check("R1 product after reset", product, 64'h0);
        rst_n = 1'b1;

        // Table walk: R3, R4 (all ones), R9 (zero operands)
        for (int i = 0; i < NV; i++) run_op(VA[i], VB[i], 0, "R3 table");

        // R6: hold with changing inputs
        held = product;
        multiplicand = 32'h5555_AAAA; multiplier = 32'h0F0F_0F0F;
        repeat (5) @(negedge clk);
        check("R6 product held", product, held);
        check("R6 done held", {63'h0, done}, 64'h1);

        // R7: start during iterations ignored
        run_op(32'h0001_0003, 32'h0000_F00D, 6, "R7 busy start");
        run_op(32'hFFFF_0001, 32'h0001_FFFF, 31, "R7 late start");

        // R4 explicit all-ones case
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 carry");
        check("R4 exact value", product, 64'hFFFF_FFFE_0000_0001);

        // R8: restart from done (checked inside run_op), R9 zero multiplier
        run_op(32'h1234_5678, 32'h0, 0, "R8 restart R9 zero");

        // R1: reset part-way through
        @(negedge clk);
        multiplicand = 32'h0000_0F00; multiplier = 32'hFFFF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run done", {63'h0, done}, 64'h0);
        check("R1 mid-run product", product, 64'h0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R1 stays idle", {63'h0, done}, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule